// File: doc/BRIEF.md
# Pin Control Register Bank for a General-Purpose I/O Port

This block holds the per-pin configuration of one general-purpose I/O port. Software changes any control bit by writing ones to a set, clear or toggle alias. Bits written as zero are untouched, so no read-modify-write sequence is ever needed. For each pin the block works out whether the GPIO logic or a peripheral owns the pad. It also produces the output value and output enable, the pull-up request, and a two-bit code that selects one of three peripheral functions.

The registers sit in groups of four word addresses. The group index is the address divided by four, and the low two address bits choose the access kind: 0 plain value, 1 set, 2 clear, 3 toggle. A read at any offset inside a group returns that group's register. The groups are:

| Group | Register | Reset |
|---|---|---|
| 0 | ownership | all ones |
| 1 | mux low bit | 0 |
| 2 | mux high bit | 0 |
| 3 | drive enable | 0 |
| 4 | open-drain | 0 |
| 5 | pull-up | 0 |
| 6 | output value | 0 |
| 7 | synchronized pin level | read-only |
| 8 | sticky reserved-code error | 0 |

A pad ring combines the outputs with the peripheral paths. Pin numbering across several ports works as follows: the upper bits of a global pin number pick the port, and the low five bits pick the bit within it.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the ownership register reads all ones and every other register reads 0. With these values pad_oe_o, pad_out_o, pad_pu_o and periph_sel_o are all 0, and gpio_own_o is all ones.
- R2: A write to offset 1 of groups 0..6 sets exactly the register bits written as one. A write to offset 1 of group 8 has no effect.
- R3: A write to offset 2 of groups 0..6 clears exactly the register bits written as one. All other bits keep their values.
- R4: A write to offset 3 of group 6 inverts the output-value bits written as one. Writes to offset 0 of any group, and to offset 3 of any group other than 6, change nothing.
- R5: A read at any of the four offsets of a group returns that group's register, following the group table. Addresses beyond group 8 read 0.
- R6: periph_sel_o bits [2i+1:2i] give pin i's function as {mux high, mux low}: function A is 00, B is 01, C is 10. The reserved code 11 is presented as 00 (function A).
- R7: Bit i of the error register (group 8) becomes 1 one clock after pin i holds the mux code 11. It stays 1 until a write to group 8 offset 2 clears it. A clear has no effect while the code is still 11.
- R8: pad_out_o equals the output-value register. pad_oe_o[i] is 1 only when ownership, drive enable and the inverse of (open-drain AND output value) are all 1 for pin i. An open-drain pin therefore drives only a 0.
- R9: pad_pu_o equals the pull-up register, whichever side owns the pin. gpio_own_o equals the ownership register.
- R10: pin_in passes through two flops. A level applied before clock edge k is readable in group 7 after edge k+1, and not after edge k.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| wr_en | input | 1 | write strobe, one access per cycle |
| wr_addr | input | ADDR_W | write word address: group in bits [ADDR_W-1:2], access kind in [1:0] |
| wr_data | input | NPINS | write data, one bit per pin |
| rd_addr | input | ADDR_W | read word address |
| rd_data | output | NPINS | register selected by rd_addr (combinational) |
| pin_in | input | NPINS | asynchronous pad levels |
| pad_out_o | output | NPINS | GPIO output value per pin |
| pad_oe_o | output | NPINS | GPIO output enable per pin |
| pad_pu_o | output | NPINS | pull-up request per pin |
| gpio_own_o | output | NPINS | 1 when the GPIO logic owns the pin |
| periph_sel_o | output | 2*NPINS | per-pin peripheral function code |

## Verification
The assertions take for granted that wr_en is never X after reset and that wr_addr is held steady while wr_en is high. They also assume pin_in is asynchronous, so they compare the level register only with pin_in from two cycles earlier, and only once two cycles have passed since reset. The stimulus drives every input at the falling edge, issues one write per cycle, and changes pin_in only between edges. Each register and alias is swept with several bit patterns. Sixteen pins carry every combination of ownership, drive, open-drain and value at once.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    localparam int NCTRL   = 7;   // groups holding alias-written registers
    localparam int GRP_OWN = 0;
    localparam int GRP_MLO = 1;
    localparam int GRP_MHI = 2;
    localparam int GRP_DRV = 3;
    localparam int GRP_OD  = 4;
    localparam int GRP_PU  = 5;
    localparam int GRP_OUT = 6;
    localparam int GRP_LVL = 7;
    localparam int GRP_ERR = 8;

    typedef enum logic [1:0] {
        AK_VAL = 2'd0,
        AK_SET = 2'd1,
        AK_CLR = 2'd2,
        AK_TGL = 2'd3
    } access_e;

    typedef struct packed {
        logic set;
        logic clr;
        logic tgl;
    } alias_cmd_t;

    function automatic alias_cmd_t decode_cmd(input logic hit, input access_e kind);
        alias_cmd_t c;
        c.set = hit && (kind == AK_SET);
        c.clr = hit && (kind == AK_CLR);
        c.tgl = hit && (kind == AK_TGL);
        return c;
    endfunction

endpackage

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_pkg::*;
#(
    parameter int             W       = 32,
    parameter logic [W-1:0]   RST_VAL = '0,
    parameter bit             HAS_TGL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  alias_cmd_t   cmd,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst)
            q <= RST_VAL;
        else if (cmd.set)
            q <= q | wdata;
        else if (cmd.clr)
            q <= q & ~wdata;
        else if (HAS_TGL && cmd.tgl)
            q <= q ^ wdata;
    end

endmodule

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end

endmodule

// File: rtl/gpio_pad_mux.sv
module gpio_pad_mux #(
    parameter int W = 32
) (
    input  logic [W-1:0]   own,
    input  logic [W-1:0]   mux_lo,
    input  logic [W-1:0]   mux_hi,
    input  logic [W-1:0]   drv,
    input  logic [W-1:0]   od,
    input  logic [W-1:0]   outv,
    input  logic [W-1:0]   pu,
    output logic [W-1:0]   pad_out,
    output logic [W-1:0]   pad_oe,
    output logic [W-1:0]   pad_pu,
    output logic [2*W-1:0] sel,
    output logic [W-1:0]   bad
);

    // open-drain pins release the pad while the value is 1
    assign pad_out = outv;
    assign pad_oe  = own & drv & ~(od & outv);
    assign pad_pu  = pu;
    assign bad     = mux_lo & mux_hi;

    for (genvar i = 0; i < W; i++) begin : g_sel
        assign sel[2*i +: 2] = bad[i] ? 2'b00 : {mux_hi[i], mux_lo[i]};
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_pkg::*;
#(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 6
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 wr_en,
    input  logic [ADDR_W-1:0]    wr_addr,
    input  logic [NPINS-1:0]     wr_data,
    input  logic [ADDR_W-1:0]    rd_addr,
    output logic [NPINS-1:0]     rd_data,
    input  logic [NPINS-1:0]     pin_in,
    output logic [NPINS-1:0]     pad_out_o,
    output logic [NPINS-1:0]     pad_oe_o,
    output logic [NPINS-1:0]     pad_pu_o,
    output logic [NPINS-1:0]     gpio_own_o,
    output logic [2*NPINS-1:0]   periph_sel_o
);

    localparam int GRP_W = ADDR_W - 2;

    logic [GRP_W-1:0] wr_grp;
    logic [GRP_W-1:0] rd_grp;
    access_e          wr_kind;
    logic [NPINS-1:0] ctrl_q [NCTRL];
    logic [NPINS-1:0] lvl_q;
    logic [NPINS-1:0] err_q;
    logic [NPINS-1:0] bad;

    assign wr_grp  = wr_addr[ADDR_W-1:2];
    assign rd_grp  = rd_addr[ADDR_W-1:2];
    assign wr_kind = access_e'(wr_addr[1:0]);

    for (genvar g = 0; g < NCTRL; g++) begin : g_reg
        alias_cmd_t cmd;
        assign cmd = decode_cmd(wr_en && (int'(wr_grp) == g), wr_kind);
        gpio_alias_reg #(
            .W       (NPINS),
            .RST_VAL ((g == GRP_OWN) ? {NPINS{1'b1}} : {NPINS{1'b0}}),
            .HAS_TGL (g == GRP_OUT)
        ) reg_i (
            .clk   (clk),
            .rst   (rst),
            .cmd   (cmd),
            .wdata (wr_data),
            .q     (ctrl_q[g])
        );
    end

    gpio_sync2 #(.W(NPINS)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pin_in),
        .q   (lvl_q)
    );

    gpio_pad_mux #(.W(NPINS)) pad_i (
        .own     (ctrl_q[GRP_OWN]),
        .mux_lo  (ctrl_q[GRP_MLO]),
        .mux_hi  (ctrl_q[GRP_MHI]),
        .drv     (ctrl_q[GRP_DRV]),
        .od      (ctrl_q[GRP_OD]),
        .outv    (ctrl_q[GRP_OUT]),
        .pu      (ctrl_q[GRP_PU]),
        .pad_out (pad_out_o),
        .pad_oe  (pad_oe_o),
        .pad_pu  (pad_pu_o),
        .sel     (periph_sel_o),
        .bad     (bad)
    );

    assign gpio_own_o = ctrl_q[GRP_OWN];

    // sticky error: a pending reserved code wins over a clear
    logic err_clr;
    assign err_clr = wr_en && (int'(wr_grp) == GRP_ERR) && (wr_kind == AK_CLR);

    always_ff @(posedge clk) begin
        if (rst)
            err_q <= '0;
        else
            err_q <= (err_q & ~(err_clr ? wr_data : '0)) | bad;
    end

    always_comb begin
        rd_data = '0;
        if (int'(rd_grp) < NCTRL)
            rd_data = ctrl_q[int'(rd_grp)];
        else if (int'(rd_grp) == GRP_LVL)
            rd_data = lvl_q;
        else if (int'(rd_grp) == GRP_ERR)
            rd_data = err_q;
    end

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 6
) (
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [NPINS-1:0]   wr_data,
    input logic [NPINS-1:0]   pin_in,
    input logic [NPINS-1:0]   out_q,
    input logic [NPINS-1:0]   own_q,
    input logic [NPINS-1:0]   drv_q,
    input logic [NPINS-1:0]   lvl_q,
    input logic [NPINS-1:0]   err_q,
    input logic [NPINS-1:0]   pad_oe_o,
    input logic [2*NPINS-1:0] periph_sel_o
);

    localparam int OUT_SET = 6 * 4 + 1;
    localparam int OUT_CLR = 6 * 4 + 2;
    localparam int OUT_TGL = 6 * 4 + 3;
    localparam int ERR_CLR = 8 * 4 + 2;

    logic [1:0] since_rst;
    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    logic sel_reserved;
    always_comb begin
        sel_reserved = 1'b0;
        for (int i = 0; i < NPINS; i++)
            if (periph_sel_o[2*i +: 2] == 2'b11) sel_reserved = 1'b1;
    end

    p_set_out_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_addr) == OUT_SET) |=> ((out_q & $past(wr_data)) == $past(wr_data)));

    p_clr_out_r3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_addr) == OUT_CLR) |=> ((out_q & $past(wr_data)) == '0));

    p_tgl_out_r4: assert property (@(posedge clk) disable iff (rst)
        (wr_en && int'(wr_addr) == OUT_TGL) |=> (out_q == ($past(out_q) ^ $past(wr_data))));

    p_idle_stable_r4: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(out_q));

    p_no_reserved_sel_r6: assert property (@(posedge clk) disable iff (rst)
        !sel_reserved);

    p_err_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && int'(wr_addr) == ERR_CLR) |=> ((err_q & $past(err_q)) == $past(err_q)));

    p_oe_gated_r8: assert property (@(posedge clk) disable iff (rst)
        (pad_oe_o & ~(own_q & drv_q)) == '0);

    p_sync_depth_r10: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (lvl_q == $past(pin_in, 2)));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) chk_i (
    .clk          (clk),
    .rst          (rst),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .pin_in       (pin_in),
    .out_q        (ctrl_q[6]),
    .own_q        (ctrl_q[0]),
    .drv_q        (ctrl_q[3]),
    .lvl_q        (lvl_q),
    .err_q        (err_q),
    .pad_oe_o     (pad_oe_o),
    .periph_sel_o (periph_sel_o)
);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;

    localparam int NP = 32;
    localparam int AW = 6;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          wr_en = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [NP-1:0] wr_data = '0;
    logic [AW-1:0] rd_addr = '0;
    logic [NP-1:0] rd_data;
    logic [NP-1:0] pin_in = '0;
    logic [NP-1:0] pad_out_o, pad_oe_o, pad_pu_o, gpio_own_o;
    logic [2*NP-1:0] periph_sel_o;

    int n_checks = 0;
    int n_fail   = 0;

    logic [NP-1:0] m [0:6];
    logic [NP-1:0] err_m;
    logic [NP-1:0] lvl_m;

    always #5 clk = ~clk;

    gpio_port_ctrl #(.NPINS(NP), .ADDR_W(AW)) dut_i (
        .clk, .rst, .wr_en, .wr_addr, .wr_data, .rd_addr, .rd_data, .pin_in,
        .pad_out_o, .pad_oe_o, .pad_pu_o, .gpio_own_o, .periph_sel_o
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [2*NP-1:0] exp_sel();
        logic [2*NP-1:0] s;
        for (int i = 0; i < NP; i++)
            s[2*i +: 2] = (m[1][i] && m[2][i]) ? 2'b00 : {m[2][i], m[1][i]};
        return s;
    endfunction

    task automatic wr(input int a, input logic [NP-1:0] d);
        int g = a / 4;
        int k = a % 4;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
        if (g < 7) begin
            if (k == 1) m[g] = m[g] | d;
            else if (k == 2) m[g] = m[g] & ~d;
            else if (k == 3 && g == 6) m[g] = m[g] ^ d;
        end else if (g == 8 && k == 2) begin
            err_m = err_m & ~d;
        end
        err_m = err_m | (m[1] & m[2]);
    endtask

    task automatic rd_chk(input string req, input int a, input logic [NP-1:0] exp);
        @(negedge clk);
        rd_addr = AW'(a);
        #1;
        chk(req, 64'(rd_data), 64'(exp));
    endtask

    task automatic pads_chk();
        #1;
        chk("R8 pad_out", 64'(pad_out_o), 64'(m[6]));
        chk("R8 pad_oe", 64'(pad_oe_o), 64'(m[0] & m[3] & ~(m[4] & m[6])));
        chk("R9 pad_pu", 64'(pad_pu_o), 64'(m[5]));
        chk("R9 gpio_own", 64'(gpio_own_o), 64'(m[0]));
        chk("R6 periph_sel", periph_sel_o, exp_sel());
    endtask

    initial begin
        #2_000_000;
        n_checks++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        logic [NP-1:0] pats [4];
        pats[0] = 32'hA5A5_5A5A; pats[1] = 32'h0000_FFFF;
        pats[2] = 32'h8000_0001; pats[3] = 32'h3C96_E10F;
        m[0] = '1;
        for (int g = 1; g < 7; g++) m[g] = '0;
        err_m = '0; lvl_m = '0;

        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        for (int g = 0; g < 9; g++)
            rd_chk("R1 reset read", g * 4, (g == 0) ? '1 : '0);
        pads_chk();
        rd_chk("R5 beyond map", 9 * 4, '0);

        // R2 R3 R4 R5 alias sweep over every control group
        for (int g = 0; g < 7; g++) begin
            for (int p = 0; p < 4; p++) begin
                wr(g * 4 + 1, pats[p]);
                rd_chk("R2 set alias", g * 4 + (p % 4), m[g]);
                wr(g * 4 + 3, pats[(p + 1) % 4]);
                rd_chk("R4 toggle alias", g * 4 + ((p + 1) % 4), m[g]);
                wr(g * 4 + 0, ~m[g]);
                rd_chk("R4 value offset ignored", g * 4 + 2, m[g]);
                pads_chk();
                wr(g * 4 + 2, pats[(p + 2) % 4]);
                rd_chk("R3 clear alias", g * 4 + 3, m[g]);
                pads_chk();
            end
            wr(g * 4 + 2, '1);
            rd_chk("R3 clear all", g * 4, m[g]);
        end
        wr(8 * 4 + 1, '1);
        rd_chk("R2 set on error group ignored", 8 * 4, err_m);

        // R6 R7 all four mux codes across pins, then sticky error
        wr(1 * 4 + 1, 32'hAAAA_AAAA);
        wr(2 * 4 + 1, 32'hCCCC_CCCC);
        pads_chk();
        rd_chk("R7 error set on code 11", 8 * 4, 32'h8888_8888);
        wr(8 * 4 + 2, '1);
        rd_chk("R7 clear blocked while 11", 8 * 4 + 1, 32'h8888_8888);
        wr(2 * 4 + 2, 32'h0000_FFFF);
        rd_chk("R7 sticky after code leaves 11", 8 * 4, 32'h8888_8888);
        wr(8 * 4 + 2, 32'h0000_00F0);
        rd_chk("R7 partial clear", 8 * 4, 32'h8888_8808);
        chk("R7 model", 64'(err_m), 64'(32'h8888_8808));
        pads_chk();

        // R8 every combination of own/drv/od/value on pins 0..15
        for (int g = 0; g < 7; g++) wr(g * 4 + 2, '1);
        wr(0 * 4 + 1, 32'h5A5A_FF00);
        wr(3 * 4 + 1, 32'h33CC_F0F0);
        wr(4 * 4 + 1, 32'h0FF0_CCCC);
        wr(6 * 4 + 1, 32'h9696_AAAA);
        wr(5 * 4 + 1, 32'h1234_5678);
        pads_chk();
        wr(6 * 4 + 3, '1);
        pads_chk();

        // R10 two-stage level path
        for (int s = 0; s < 4; s++) begin
            @(negedge clk);
            pin_in = pats[s];
            @(negedge clk);
            rd_addr = AW'(7 * 4);
            #1;
            chk("R10 not yet after one edge", 64'(rd_data), 64'(lvl_m));
            @(negedge clk);
            #1;
            chk("R10 visible after two edges", 64'(rd_data), 64'(pats[s]));
            lvl_m = pats[s];
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule